// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the internal word address for a synchronous flow-through memory that runs four-beat bursts. On each rising clock edge it samples an external address, a processor strobe, a controller strobe, a chip enable, an advance input and an order-select pin. A strobe that is accepted loads the full address. The low two bits become the starting offset of a burst. Later cycles with the advance input high step a 2-bit beat index, and the low address bits follow it in linear or interleaved order.

A burst gives one loaded access and then three advanced ones, the 2-1-1-1 pattern. After the fourth beat the address returns to the starting offset; the upper address bits never change within a burst. A deasserted advance input suspends the burst, and a strobe that arrives mid-burst restarts it at the new address. The two strobes follow different rules. The processor strobe counts only while the chip is enabled. The controller strobe is always sampled, so with the enable low it deselects the block.

Top module: `burst_addr_seq`

## Requirements
- R1: A clock edge with `rst` high clears `mem_valid` to 0 and `mem_addr` to 0.
- R2: An edge with `strb_proc` high and `chip_en` high loads `addr_in`. After that edge `mem_valid` is 1 and `mem_addr` equals the sampled `addr_in`.
- R3: With `order_sel` sampled at 0 (linear), the address after the n-th advance has low bits (start + n) mod 4. The bits above bit 1 stay equal to the loaded address.
- R4: With `order_sel` sampled at 1 (interleaved), the address after the n-th advance has low bits start XOR n.
- R5: `order_sel` is captured only on a load edge. Changing it during a burst does not change the order of that burst.
- R6: An edge without a strobe and with `advance` low leaves `mem_addr` and `mem_valid` unchanged.
- R7: The fourth advance after a load returns `mem_addr` to the loaded address, and the sequence then repeats.
- R8: A strobe accepted during a burst loads the new address and restarts the beat index at 0. On a load edge `advance` has no effect.
- R9: An edge with `strb_proc` high, `chip_en` low and `strb_ctrl` low does nothing: `mem_addr` and `mem_valid` keep their values.
- R10: An edge with `strb_ctrl` high and `chip_en` low clears `mem_valid`. While `mem_valid` is 0, `advance` leaves `mem_addr` unchanged.
- R11: An edge with `strb_ctrl` high and `chip_en` high loads `addr_in`, exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address, sampled on a load edge |
| strb_proc | input | 1 | Processor address strobe, active high, accepted only while enabled |
| strb_ctrl | input | 1 | Controller address strobe, active high, always sampled |
| chip_en | input | 1 | Chip enable, active high |
| advance | input | 1 | Steps the burst one beat when no strobe is present |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| mem_addr | output | ADDR_W | Address presented to the memory array |
| mem_valid | output | 1 | The address is for a selected access |

## Verification
The assertions take all inputs as stable around the rising edge and free of unknown values once reset is released. They also expect reset to be held over the first clock edge. The bench changes inputs only on the falling edge and holds reset for the first several cycles. It drives every control input to a defined 0 or 1 on every cycle, including the strobes while they are idle.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;

  // Low address bits for a given beat of a burst.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] idx,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ idx;
    else     r = start + idx;   // 2-bit add wraps modulo 4
    return r;
  endfunction

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb (
  input  logic strb_proc,
  input  logic strb_ctrl,
  input  logic chip_en,
  output logic load_evt,
  output logic desel_evt
);
  logic proc_take;
  logic ctrl_take;

  // The processor strobe is accepted only while enabled, and it has priority.
  assign proc_take = strb_proc & chip_en;
  assign ctrl_take = strb_ctrl & ~proc_take;

  assign load_evt  = proc_take | (ctrl_take & chip_en);
  assign desel_evt = ctrl_take & ~chip_en;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_evt,
  input  logic       desel_evt,
  input  logic       advance,
  input  logic       order_in,
  output logic [1:0] beat_idx,
  output logic       active,
  output logic       ilv_mode
);
  logic step_evt;
  assign step_evt = active & advance & ~load_evt & ~desel_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_idx <= 2'd0;
      active   <= 1'b0;
      ilv_mode <= 1'b0;
    end else if (load_evt) begin
      beat_idx <= 2'd0;
      active   <= 1'b1;
      ilv_mode <= order_in;
    end else if (desel_evt) begin
      active   <= 1'b0;
    end else if (step_evt) begin
      beat_idx <= beat_idx + 2'd1;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> beat_idx == $past(beat_idx) + 2'd1); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(ilv_mode)); // R5
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_addr
);
  always_ff @(posedge clk) begin
    if (rst)           base_addr <= '0;
    else if (load_evt) base_addr <= addr_in;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_proc,
  input  logic              strb_ctrl,
  input  logic              chip_en,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_valid
);
  import burst_addr_seq_pkg::*;

  localparam int UP_W = ADDR_W - 2;

  logic              load_evt;
  logic              desel_evt;
  logic [1:0]        beat_idx;
  logic              ilv_mode;
  logic [ADDR_W-1:0] base_addr;

  burst_strobe_arb u_arb (
    .strb_proc (strb_proc),
    .strb_ctrl (strb_ctrl),
    .chip_en   (chip_en),
    .load_evt  (load_evt),
    .desel_evt (desel_evt)
  );

  burst_beat_ctr u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load_evt  (load_evt),
    .desel_evt (desel_evt),
    .advance   (advance),
    .order_in  (order_sel),
    .beat_idx  (beat_idx),
    .active    (mem_valid),
    .ilv_mode  (ilv_mode)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk       (clk),
    .rst       (rst),
    .load_evt  (load_evt),
    .addr_in   (addr_in),
    .base_addr (base_addr)
  );

  assign mem_addr = {base_addr[ADDR_W-1:2], beat_low(base_addr[1:0], beat_idx, ilv_mode)};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !mem_valid && mem_addr == '0); // R1
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (strb_proc || strb_ctrl) && chip_en |=> mem_valid && mem_addr == $past(addr_in)); // R2
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    !((strb_proc || strb_ctrl) && chip_en) |=> $stable(mem_addr[ADDR_W-1:2])); // R3
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    !strb_proc && !strb_ctrl && !advance |=> $stable(mem_addr) && $stable(mem_valid)); // R6
  AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    strb_proc && !chip_en && !strb_ctrl && !advance |=> $stable(mem_addr) && $stable(mem_valid)); // R9
  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    strb_ctrl && !chip_en |=> !mem_valid); // R10
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          strb_proc = 1'b0, strb_ctrl = 1'b0, chip_en = 1'b0;
  logic          advance = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .strb_proc(strb_proc),
    .strb_ctrl(strb_ctrl), .chip_en(chip_en), .advance(advance),
    .order_sel(order_sel), .mem_addr(mem_addr), .mem_valid(mem_valid)
  );

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] a, input int n, input bit ilv);
    int s, lo;
    s  = int'(a[1:0]);
    lo = ilv ? (s ^ (n % 4)) : ((s + n) % 4);
    return {a[AW-1:2], 2'(lo)};
  endfunction

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic cyc(input bit p, input bit c, input bit en, input bit adv,
                     input bit md, input logic [AW-1:0] a);
    @(negedge clk);
    strb_proc = p; strb_ctrl = c; chip_en = en; advance = adv; order_sel = md; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [AW-1:0] ga, input logic [AW-1:0] ea,
                     input logic gv, input logic ev);
    checks++;
    if (ga !== ea || gv !== ev) begin
      errors++;
      $display("FAIL %s addr=%h valid=%b expected addr=%h valid=%b", tag, ga, gv, ea, ev);
    end
  endtask

  task automatic t_reset;
    cyc(0, 0, 0, 0, 0, '0);
    chk("R1 reset", mem_addr, '0, mem_valid, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_linear;
    logic [AW-1:0] a = 19'h12345;
    cyc(1, 0, 1, 0, 0, a);
    chk("R2 proc load", mem_addr, a, mem_valid, 1'b1);
    for (int n = 1; n < 4; n++) begin
      cyc(0, 0, 1, 1, 0, 19'h7ffff);
      chk("R3 linear beat", mem_addr, expect_addr(a, n, 0), mem_valid, 1'b1);
    end
    cyc(0, 0, 1, 1, 0, '0);
    chk("R7 wrap to start", mem_addr, a, mem_valid, 1'b1);
    cyc(0, 0, 1, 1, 0, '0);
    chk("R7 repeat after wrap", mem_addr, expect_addr(a, 1, 0), mem_valid, 1'b1);
  endtask

  task automatic t_interleave;
    logic [AW-1:0] a = 19'h0abc2;
    cyc(0, 1, 1, 0, 1, a);
    chk("R11 ctrl load", mem_addr, a, mem_valid, 1'b1);
    for (int n = 1; n < 4; n++) begin
      cyc(0, 0, 1, 1, 1, '0);
      chk("R4 interleaved beat", mem_addr, expect_addr(a, n, 1), mem_valid, 1'b1);
    end
    a = 19'h55553;
    cyc(1, 1, 1, 0, 1, a);
    for (int n = 1; n < 4; n++) begin
      cyc(0, 0, 1, 1, 1, '0);
      chk("R4 interleaved from 3", mem_addr, expect_addr(a, n, 1), mem_valid, 1'b1);
    end
  endtask

  task automatic t_hold_and_mode;
    logic [AW-1:0] a = 19'h00401;
    cyc(1, 0, 1, 0, 1, a);
    cyc(0, 0, 1, 1, 0, '0);   // order_sel flipped mid-burst
    chk("R5 order latched", mem_addr, expect_addr(a, 1, 1), mem_valid, 1'b1);
    cyc(0, 0, 1, 0, 0, '0);
    chk("R6 suspend", mem_addr, expect_addr(a, 1, 1), mem_valid, 1'b1);
    cyc(0, 0, 0, 0, 1, 19'h3ffff);
    chk("R6 suspend again", mem_addr, expect_addr(a, 1, 1), mem_valid, 1'b1);
    cyc(0, 0, 1, 1, 0, '0);
    chk("R5 resume same order", mem_addr, expect_addr(a, 2, 1), mem_valid, 1'b1);
  endtask

  task automatic t_restart;
    logic [AW-1:0] b = 19'h6e6e1;
    cyc(1, 0, 1, 0, 0, 19'h11110);
    cyc(0, 0, 1, 1, 0, '0);
    cyc(1, 0, 1, 1, 0, b);    // advance high on load edge
    chk("R8 restart load", mem_addr, b, mem_valid, 1'b1);
    cyc(0, 0, 1, 1, 0, '0);
    chk("R8 beat index reset", mem_addr, expect_addr(b, 1, 0), mem_valid, 1'b1);
  endtask

  task automatic t_ignore_and_desel;
    logic [AW-1:0] cur;
    cyc(1, 0, 1, 0, 0, 19'h22222);
    cur = mem_addr;
    cyc(1, 0, 0, 0, 0, 19'h7f00f);
    chk("R9 proc ignored", mem_addr, cur, mem_valid, 1'b1);
    cyc(1, 1, 0, 0, 0, 19'h0000c);
    chk("R10 deselect", mem_addr, cur, mem_valid, 1'b0);
    cyc(0, 0, 1, 1, 0, '0);
    chk("R10 advance while idle", mem_addr, cur, mem_valid, 1'b0);
    cyc(0, 1, 1, 0, 0, 19'h4321f);
    chk("R11 ctrl reload", mem_addr, 19'h4321f, mem_valid, 1'b1);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_linear;
    t_interleave;
    t_hold_and_mode;
    t_restart;
    t_ignore_and_desel;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule